// File: doc/BRIEF.md
# DDS Frequency Sweep Controller

This block drives a direct digital synthesizer through a stepped frequency sweep. Software or a host supplies three 32-bit tuning words: the word for the first point, the increment between points, and an upper limit. A one-cycle start pulse begins the sweep. For each point the block forms a 40-bit load frame, shifts it out serially with a divided clock and then pulses a load strobe. It waits a fixed settle interval, then raises a one-cycle measurement request. The next point begins only after a measurement acknowledge comes back.

Each point's tuning word is the previous word plus the increment, so no divider is needed. The tuning word for a frequency F with a 150 MHz synthesizer clock is F·2^32/150e6, and the host works it out before the sweep begins. The sweep stops after the last point whose word does not pass the limit. A done flag then rises and stays high until the next start.

Top module: `sweep_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset, sclk_o, sdata_o, load_o, meas_req_o, busy_o and done_o are all 0.
- R2: Each frame is 40 bits and is sent bit 0 first. Bits 31:0 hold the tuning word, LSB first. Bit 32 is the clock-multiplier enable and is 1. Bit 33 is reserved and is 0, bit 34 is power-down and is 0, and bits 39:35 form the phase field, which is always 0.
- R3: sclk_o is low when idle. Each high phase lasts exactly CLK_DIV clock cycles, and so does each low phase within a frame. sdata_o changes only while sclk_o is low, so the receiver samples it on the rising sclk_o edge.
- R4: After the 40th rising sclk_o edge, load_o goes high for exactly CLK_DIV cycles while sclk_o is low. There is exactly one strobe per frame.
- R5: meas_req_o is a one-cycle pulse. It rises exactly SETTLE_CYCLES clock cycles after load_o falls.
- R6: The words sent are start, start+step, start+2·step and so on, ending with the last one that is not greater than the stop word. A sum that carries out of 32 bits also ends the sweep.
- R7: On the clock edge that samples meas_ack_i for the final point, done_o becomes 1 and busy_o becomes 0. done_o stays 1 until the next accepted start, and that start clears it.
- R8: No new frame begins until meas_ack_i is sampled high while a request is outstanding. An acknowledge at any other time has no effect.
- R9: start_i is ignored while busy_o is 1. The start, step and stop words are captured when a start is accepted, and later changes to them have no effect on the running sweep.
- R10: If start equals stop, if the step is zero, or if start is greater than stop, exactly one point (the start word) is loaded and measured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a sweep |
| start_word_i | input | 32 | Tuning word of the first point |
| step_word_i | input | 32 | Tuning-word increment per point |
| stop_word_i | input | 32 | Highest tuning word allowed |
| sclk_o | output | 1 | Serial clock to the synthesizer |
| sdata_o | output | 1 | Serial data, valid on the rising sclk_o edge |
| load_o | output | 1 | Frame load strobe |
| meas_req_o | output | 1 | One-cycle measurement request |
| meas_ack_i | input | 1 | Measurement complete acknowledge |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished, held until next start |

## Verification
The hardest case to reach from the ports is the end of a sweep caused by a 32-bit carry rather than by the stop comparison. The stimulus places the start word a few steps below 2^32 with the stop word at all ones, so that the only thing that can end the sweep is the carry out of the adder. Random sweeps choose a point count, then derive a stop word from it with a random slack smaller than one step. Random acknowledge delays are mixed in, together with stray acknowledges and start pulses sent while a frame is shifting or a request is outstanding.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  localparam int unsigned CTRL_W = 8;
  // control byte: bit0 multiplier enable, bit1 reserved, bit2 power-down, bits7:3 phase
  localparam logic [CTRL_W-1:0] CTRL_BYTE = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SHIFT, ST_SETTLE, ST_REQ, ST_WAIT
  } sweep_state_e;

  typedef enum logic [1:0] {
    SER_IDLE, SER_LOW, SER_HIGH, SER_LOAD
  } ser_state_e;
endpackage

// File: rtl/sweep_serializer.sv
module sweep_serializer
  import sweep_pkg::*;
#(
  parameter int unsigned FRAME_W = 40,
  parameter int unsigned CLK_DIV = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sclk_o,
  output logic               sdata_o,
  output logic               load_o,
  output logic               done_o
);
  localparam int unsigned CNT_W = (CLK_DIV < 2) ? 1 : $clog2(CLK_DIV);
  localparam int unsigned IDX_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

  ser_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SER_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      sclk_o  <= 1'b0;
      sdata_o <= 1'b0;
      load_o  <= 1'b0;
    end else begin
      unique case (state_q)
        SER_IDLE: if (go_i) begin
          shreg_q <= frame_i;
          sdata_o <= frame_i[0];
          idx_q   <= '0;
          cnt_q   <= '0;
          state_q <= SER_LOW;
        end
        SER_LOW: if (cnt_q == CNT_LAST) begin
          cnt_q   <= '0;
          sclk_o  <= 1'b1;
          state_q <= SER_HIGH;
        end else cnt_q <= cnt_q + 1'b1;
        SER_HIGH: if (cnt_q == CNT_LAST) begin
          cnt_q  <= '0;
          sclk_o <= 1'b0;
          if (idx_q == IDX_LAST) begin
            load_o  <= 1'b1;
            sdata_o <= 1'b0;
            state_q <= SER_LOAD;
          end else begin
            idx_q   <= idx_q + 1'b1;
            shreg_q <= shreg_q >> 1;
            sdata_o <= shreg_q[1];
            state_q <= SER_LOW;
          end
        end else cnt_q <= cnt_q + 1'b1;
        SER_LOAD: if (cnt_q == CNT_LAST) begin
          cnt_q   <= '0;
          load_o  <= 1'b0;
          state_q <= SER_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
        default: state_q <= SER_IDLE;
      endcase
    end
  end

  assign done_o = (state_q == SER_LOAD) && (cnt_q == CNT_LAST);

  AST_SDATA_SCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(sdata_o) |-> !sclk_o); // R3
  AST_LOAD_SCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> !sclk_o); // R4
endmodule

// File: rtl/sweep_stepper.sv
module sweep_stepper #(
  parameter int unsigned FTW_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             adv_i,
  input  logic [FTW_W-1:0] start_word_i,
  input  logic [FTW_W-1:0] step_word_i,
  input  logic [FTW_W-1:0] stop_word_i,
  output logic [FTW_W-1:0] word_o,
  output logic             last_o
);
  logic [FTW_W-1:0] cur_q, step_q, stop_q;
  logic [FTW_W:0]   sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      step_q <= '0;
      stop_q <= '0;
    end else if (init_i) begin
      cur_q  <= start_word_i;
      step_q <= step_word_i;
      stop_q <= stop_word_i;
    end else if (adv_i) begin
      cur_q <= sum[FTW_W-1:0];
    end
  end

  assign sum    = {1'b0, cur_q} + {1'b0, step_q};
  // carry out, overshoot or a zero step all end the sweep
  assign last_o = sum[FTW_W] || (sum[FTW_W-1:0] > stop_q) || (step_q == '0);
  assign word_o = cur_q;

  AST_ADV_NOT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> !last_o); // R6
  AST_NO_OVERSHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (word_o <= stop_q)); // R6
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int unsigned FTW_W         = 32,
  parameter int unsigned CLK_DIV       = 2,
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [FTW_W-1:0] start_word_i,
  input  logic [FTW_W-1:0] step_word_i,
  input  logic [FTW_W-1:0] stop_word_i,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             load_o,
  output logic             meas_req_o,
  input  logic             meas_ack_i,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned FRAME_W = FTW_W + CTRL_W;
  localparam int unsigned SET_W   = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYCLES - 1);

  sweep_state_e     state_q;
  logic [SET_W-1:0] set_cnt_q;
  logic             go_q, done_q;
  logic             init, adv, last, ser_done;
  logic [FTW_W-1:0] word;

  assign init = (state_q == ST_IDLE) && start_i;
  assign adv  = (state_q == ST_WAIT) && meas_ack_i && !last;

  sweep_stepper #(.FTW_W(FTW_W)) u_stepper (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .init_i       (init),
    .adv_i        (adv),
    .start_word_i (start_word_i),
    .step_word_i  (step_word_i),
    .stop_word_i  (stop_word_i),
    .word_o       (word),
    .last_o       (last)
  );

  sweep_serializer #(.FRAME_W(FRAME_W), .CLK_DIV(CLK_DIV)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go_q),
    .frame_i ({CTRL_BYTE, word}),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .load_o  (load_o),
    .done_o  (ser_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      set_cnt_q <= '0;
      go_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      go_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SHIFT;
          go_q    <= 1'b1;
          done_q  <= 1'b0;
        end
        ST_SHIFT: if (ser_done) begin
          set_cnt_q <= '0;
          state_q   <= ST_SETTLE;
        end
        ST_SETTLE: if (set_cnt_q == SET_LAST) state_q <= ST_REQ;
                   else set_cnt_q <= set_cnt_q + 1'b1;
        ST_REQ: state_q <= ST_WAIT;
        ST_WAIT: if (meas_ack_i) begin
          if (last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_SHIFT;
            go_q    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign meas_req_o = (state_q == ST_REQ);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_req_o |=> !meas_req_o); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !load_o)); // R3
  AST_REQ_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_req_o |-> (!sclk_o && !load_o)); // R8
endmodule

// File: tb/sweep_ctrl_test.sv
module sweep_ctrl_test;
  localparam int DIV = 2;
  localparam int SETTLE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ack = 1'b0;
  logic [31:0] sw = '0, stw = '0, spw = '0;
  logic sclk, sdata, load, req, busy, done;

  always #2.5 clk = ~clk;

  sweep_ctrl #(.FTW_W(32), .CLK_DIV(DIV), .SETTLE_CYCLES(SETTLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_word_i(sw),
    .step_word_i(stw), .stop_word_i(spw), .sclk_o(sclk), .sdata_o(sdata),
    .load_o(load), .meas_req_o(req), .meas_ack_i(ack), .busy_o(busy), .done_o(done));

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [39:0] frames[64];
  int nfr = 0, nreq = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // serial receiver model and timing monitor
  logic p_sclk = 0, p_load = 0, p_sdata = 0;
  logic [39:0] rx = '0;
  int bitcnt = 0, hi_w = 0, ld_w = 0, k = 0;
  bit settle_on = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && !p_sclk) begin
        rx = {sdata, rx[39:1]};
        bitcnt++;
        hi_w = 1;
      end else if (sclk) begin
        hi_w++;
        if (sdata !== p_sdata) chk(0, "R3 sdata moved while sclk high", sdata, p_sdata);
      end
      if (!sclk && p_sclk) chk(hi_w == DIV, "R3 sclk high width", hi_w, DIV);
      if (load && !p_load) begin
        chk(bitcnt == 40, "R4 bits before load", bitcnt, 40);
        chk(!sclk, "R4 sclk low at load", sclk, 0);
        if (nfr < 64) frames[nfr] = rx;
        nfr++;
        bitcnt = 0;
        ld_w = 1;
      end else if (load) ld_w++;
      if (settle_on) begin
        k++;
        if (req) begin
          chk(k == SETTLE, "R5 settle cycles", k, SETTLE);
          settle_on = 0;
        end
      end
      if (!load && p_load) begin
        chk(ld_w == DIV, "R4 load width", ld_w, DIV);
        k = 0;
        settle_on = 1;
      end
      if (req) nreq++;
      p_sclk = sclk; p_load = load; p_sdata = sdata;
    end
  end

  task automatic run_sweep(input logic [31:0] s, input logic [31:0] st, input logic [31:0] sp,
                           input bit disturb, input string name);
    logic [31:0] expw[64];
    logic [32:0] w;
    int n = 0;
    bit quiet, got;
    w = {1'b0, s};
    forever begin
      expw[n] = w[31:0];
      n++;
      if (st == 0 || n >= 64) break;
      w = w + {1'b0, st};
      if (w[32] || w[31:0] > sp) break;
    end
    @(negedge clk);
    sw = s; stw = st; spw = sp;
    nfr = 0; nreq = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, {"R7 busy after start ", name}, {busy, done}, 2'b10);
    if (disturb) begin
      repeat (6) @(negedge clk);
      ack = 1'b1;  // stray ack during shifting, R8
      @(negedge clk);
      ack = 1'b0;
    end
    for (int p = 0; p < n; p++) begin
      got = 0;
      for (int t = 0; t < 5000 && !got; t++) begin
        @(negedge clk);
        if (req) got = 1;
      end
      chk(got, {"R5 request seen ", name}, got, 1);
      if (!got) return;
      quiet = 1;
      for (int d = 0; d < int'($urandom % 6) + 1; d++) begin
        if (disturb && p == 0 && d == 0) begin
          start = 1'b1;         // R9 start while busy
          stw = st + 32'd5;     // R9 changed step after start
        end
        @(negedge clk);
        start = 1'b0;
        if (sclk || load) quiet = 0;
      end
      chk(quiet, {"R8 no frame before ack ", name}, quiet, 1);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      if (p == n - 1) chk(done && !busy, {"R7 done after last ack ", name}, {done, busy}, 2'b10);
      else chk(!done && busy, {"R7 running mid sweep ", name}, {done, busy}, 2'b01);
    end
    repeat (3) @(negedge clk);
    chk(nfr == n, {"R6 R10 frame count ", name}, nfr, n);
    chk(nreq == n, {"R5 request count ", name}, nreq, n);
    for (int i = 0; i < n && i < nfr && i < 64; i++)
      chk(frames[i] == {8'h01, expw[i]}, {"R2 R6 frame value ", name}, frames[i], {8'h01, expw[i]});
    chk(done && !sclk && !load, {"R7 done held ", name}, done, 1);
  endtask

  function automatic logic [31:0] ftw_of(input longint hz);
    return 32'((hz << 32) / 150_000_000);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    int unused_seed;
    logic [31:0] s, st, sp;
    int n;
    unused_seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk({sclk, sdata, load, req, busy, done} == 6'b0, "R1 outputs in reset", {sclk, sdata, load, req, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({sclk, sdata, load, req, busy, done} == 6'b0, "R1 outputs after reset", {sclk, sdata, load, req, busy, done}, 0);

    run_sweep(ftw_of(1000), ftw_of(10), ftw_of(1100), 1'b0, "ref 1k-1.1k");
    run_sweep(32'h1234_5678, 32'h100, 32'h1234_5678, 1'b0, "R10 start eq stop");
    run_sweep(32'h0000_4000, 32'h0, 32'hFFFF_0000, 1'b0, "R10 zero step");
    run_sweep(32'h8000_0000, 32'h10, 32'h7000_0000, 1'b0, "R10 start gt stop");
    run_sweep(32'hFFFF_FF00, 32'h80, 32'hFFFF_FFFF, 1'b0, "R6 carry end");
    run_sweep(32'h0000_1000, 32'h0000_0200, 32'h0000_1800, 1'b1, "R8 R9 disturbed");
    for (int r = 0; r < 6; r++) begin
      s  = $urandom & 32'h3FFF_FFFF;
      st = ($urandom & 32'h00FF_FFFF) + 32'd1;
      n  = int'($urandom % 8) + 1;
      sp = s + st * 32'(n - 1) + ($urandom % st);
      run_sweep(s, st, sp, r[0], "random");
    end
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=%0d exp=0", 1);
    summary();
  end
endmodule